// File: doc/BRIEF.md
# Command-Driven Protection and Low-Page Bank Unit

This unit sits on a 24-bit CPU bus and behaves as a small protection device. The CPU writes a data byte and a command byte into two registers. Any byte read inside the device window returns a value derived from the stored data byte. Which transform is applied depends on the command: shift right by one, nibble swap, or full bit reversal. Command values that are not defined read back as zero. The read result is combinational and is valid in the same cycle as the read strobe.

A second write window holds a page register. It redirects the lowest 32 KB of the CPU address space to any 32 KB page of the ROM. Page 0 gives the original low window. A page that would run past the configured ROM size is dropped, and the previous mapping stays in place. All addresses at or above 0x8000 pass through untranslated. ROM storage and the wider bus decode are outside this unit.

Top module: `cmd_prot_bank`

## Requirements
- R1: A byte write to 0x600000..0x6FFFFF with address bit 1 set loads the command register from the write data on the next clock edge.
- R2: A byte write to 0x600000..0x6FFFFF with address bit 1 clear loads the data register on the next clock edge.
- R3: While the read strobe is high and the address lies in 0x600000..0x7FFFFF, the read data shows the transformed value in the same cycle. Otherwise the read data is 0x00.
- R4: Command 0x01 returns the data byte shifted right by one bit, with a zero shifted into bit 7.
- R5: Command 0x02 returns the data byte with its upper and lower nibbles exchanged.
- R6: Command 0x03 returns the data byte with bit i moved to bit 7-i for every i.
- R7: Any command value other than 0x01, 0x02 or 0x03 returns 0x00.
- R8: A byte write to 0x700000..0x7FFFFF with data p selects page p. From the next cycle, CPU addresses 0x0000..0x7FFF translate to p*0x8000 plus the low 15 address bits.
- R9: Page 0 maps CPU addresses 0x0000..0x7FFF onto themselves.
- R10: A page write whose page end, (p+1)*0x8000, exceeds ROM_BYTES leaves the page register unchanged. The last page that fits is accepted.
- R11: CPU addresses of 0x8000 and above appear on the translated address unchanged.
- R12: Reset clears the command, data and page registers.
- R13: Writes outside 0x600000..0x7FFFFF change no register. Page writes leave command and data unchanged, and command or data writes leave the page unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | CPU byte address |
| rd_en | input | 1 | Byte read strobe |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| rd_data | output | 8 | Transformed read value |
| rom_addr | output | 24 | Translated ROM address |

## Verification
The hardest case to reach is the page range limit. The last page that fits must be accepted, and the first page that does not fit must leave the earlier mapping in place. Neither case can be seen at the ports without a later translated lookup. The stimulus therefore first writes the highest legal page and checks the top byte of the low window. It then writes the first out-of-range page and looks up address zero, which must still point at the previously accepted page. A similar indirect look is used to show that writes to one register family do not touch the other.

// File: rtl/cmd_prot_bank.sv
module cmd_prot_bank #(
  parameter int ADDR_W    = 24,
  parameter int ROM_BYTES = 32'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rom_addr
);
  localparam int PAGE_SH = 15;
  localparam int PAGES   = ROM_BYTES >> PAGE_SH;
  localparam int HI_W    = ADDR_W - 20;
  localparam int PG_W    = ADDR_W - PAGE_SH;

  logic [7:0] cmd_q, data_q, page_q;
  logic [7:0] xform, rev;
  logic       in_reg, in_page, in_win, low_win, page_ok;

  assign in_reg  = cpu_addr[ADDR_W-1:20] == HI_W'(6);
  assign in_page = cpu_addr[ADDR_W-1:20] == HI_W'(7);
  assign in_win  = in_reg | in_page;
  assign low_win = cpu_addr[ADDR_W-1:PAGE_SH] == '0;
  assign page_ok = int'(wr_data) < PAGES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      page_q <= '0;
    end else if (wr_en) begin
      if (in_reg && cpu_addr[1])  cmd_q  <= wr_data;
      if (in_reg && !cpu_addr[1]) data_q <= wr_data;
      if (in_page && page_ok)     page_q <= wr_data;
    end
  end

  always_comb begin
    for (int i = 0; i < 8; i++) rev[i] = data_q[7-i];
    unique case (cmd_q)
      8'h01:   xform = {1'b0, data_q[7:1]};
      8'h02:   xform = {data_q[3:0], data_q[7:4]};
      8'h03:   xform = rev;
      default: xform = '0;
    endcase
  end

  assign rd_data  = (rd_en && in_win) ? xform : 8'h00;
  assign rom_addr = low_win ? {PG_W'(page_q), cpu_addr[PAGE_SH-1:0]} : cpu_addr;
endmodule

// File: rtl/cmd_prot_bank_chk.sv
module cmd_prot_bank_chk #(
  parameter int ADDR_W    = 24,
  parameter int ROM_BYTES = 32'h400000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [7:0]        cmd_q,
  input logic [7:0]        data_q,
  input logic [7:0]        page_q
);
  localparam int PAGES = ROM_BYTES >> 15;
  logic s6, s7;
  assign s6 = cpu_addr[ADDR_W-1:20] == (ADDR_W-20)'(6);
  assign s7 = cpu_addr[ADDR_W-1:20] == (ADDR_W-20)'(7);

  a_r1_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && s6 && cpu_addr[1] |=> cmd_q == $past(wr_data));
  a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && s6 && !cpu_addr[1] |=> data_q == $past(wr_data));
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (s6 || s7)) |-> rd_data == 8'h00);
  a_r4_halve: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && s6 && cmd_q == 8'h01 |-> rd_data == {1'b0, data_q[7:1]});
  a_r10_oob_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && s7 && int'(wr_data) >= PAGES |=> $stable(page_q));
  a_r11_pass: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr >= ADDR_W'(32'h8000) |-> rom_addr == cpu_addr);
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (s6 || s7)) |=> $stable(cmd_q) && $stable(data_q) && $stable(page_q));
endmodule

bind cmd_prot_bank cmd_prot_bank_chk #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .rom_addr(rom_addr),
  .cmd_q(cmd_q), .data_q(data_q), .page_q(page_q));

// File: tb/cmd_prot_bank_tb_top.sv
`timescale 1ns/1ps
module cmd_prot_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [23:0] rom_addr;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmd_prot_bank dut_i (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rom_addr(rom_addr));

  // op: 0 write, 1 read check, 2 translate check
  localparam int NV = 32;
  localparam logic [63:0] VEC [NV] = '{
    {2'd0, 24'h600000, 8'hB4, 24'h000000, 4'd2,  2'b0},  // R2
    {2'd0, 24'h600002, 8'h01, 24'h000000, 4'd1,  2'b0},  // R1
    {2'd1, 24'h600000, 8'h00, 24'h00005A, 4'd4,  2'b0},  // R4
    {2'd0, 24'h600003, 8'h02, 24'h000000, 4'd1,  2'b0},
    {2'd1, 24'h7ABCDE, 8'h00, 24'h00004B, 4'd5,  2'b0},  // R5, R3
    {2'd0, 24'h600006, 8'h03, 24'h000000, 4'd1,  2'b0},
    {2'd1, 24'h6FFFFF, 8'h00, 24'h00002D, 4'd6,  2'b0},  // R6
    {2'd0, 24'h60000A, 8'h00, 24'h000000, 4'd1,  2'b0},
    {2'd1, 24'h600001, 8'h00, 24'h000000, 4'd7,  2'b0},  // R7
    {2'd0, 24'h600002, 8'hFF, 24'h000000, 4'd1,  2'b0},
    {2'd1, 24'h600001, 8'h00, 24'h000000, 4'd7,  2'b0},
    {2'd0, 24'h600002, 8'h03, 24'h000000, 4'd1,  2'b0},
    {2'd1, 24'h5FFFFF, 8'h00, 24'h000000, 4'd3,  2'b0},  // R3
    {2'd1, 24'h800000, 8'h00, 24'h000000, 4'd3,  2'b0},
    {2'd0, 24'h700000, 8'h05, 24'h000000, 4'd8,  2'b0},  // R8
    {2'd2, 24'h001234, 8'h00, 24'h029234, 4'd8,  2'b0},
    {2'd2, 24'h008000, 8'h00, 24'h008000, 4'd11, 2'b0},  // R11
    {2'd2, 24'h3FFFFF, 8'h00, 24'h3FFFFF, 4'd11, 2'b0},
    {2'd0, 24'h7FFFFF, 8'h7F, 24'h000000, 4'd10, 2'b0},  // R10 last page
    {2'd2, 24'h007FFF, 8'h00, 24'h3FFFFF, 4'd10, 2'b0},
    {2'd0, 24'h700001, 8'h80, 24'h000000, 4'd10, 2'b0},  // R10 first bad page
    {2'd2, 24'h000000, 8'h00, 24'h3F8000, 4'd10, 2'b0},
    {2'd0, 24'h500000, 8'h00, 24'h000000, 4'd13, 2'b0},  // R13
    {2'd0, 24'hA13002, 8'h00, 24'h000000, 4'd13, 2'b0},
    {2'd1, 24'h600000, 8'h00, 24'h00002D, 4'd13, 2'b0},
    {2'd2, 24'h000000, 8'h00, 24'h3F8000, 4'd13, 2'b0},
    {2'd0, 24'h700002, 8'h03, 24'h000000, 4'd8,  2'b0},
    {2'd1, 24'h600000, 8'h00, 24'h00002D, 4'd13, 2'b0},
    {2'd0, 24'h600000, 8'h11, 24'h000000, 4'd2,  2'b0},
    {2'd2, 24'h000010, 8'h00, 24'h018010, 4'd13, 2'b0},
    {2'd0, 24'h700000, 8'h00, 24'h000000, 4'd9,  2'b0},  // R9
    {2'd2, 24'h001234, 8'h00, 24'h001234, 4'd9,  2'b0}
  };

  task automatic chk(input int req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input int req, input logic [7:0] exp);
    @(negedge clk); cpu_addr = a; rd_en = 1'b1;
    #1 chk(req, {16'h0, rd_data}, {16'h0, exp});
    rd_en = 1'b0;
  endtask

  task automatic xl(input logic [23:0] a, input int req, input logic [23:0] exp);
    @(negedge clk); cpu_addr = a;
    #1 chk(req, rom_addr, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state: page identity, data cleared, command cleared
    xl(24'h004321, 12, 24'h004321);
    rd(24'h600000, 12, 8'h00);
    wr(24'h600002, 8'h02);
    rd(24'h600000, 12, 8'h00);
    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      v = VEC[i];
      case (v[63:62])
        2'd0: wr(v[61:38], v[37:30]);
        2'd1: rd(v[61:38], int'(v[5:2]), v[13:6]);
        default: xl(v[61:38], int'(v[5:2]), v[29:6]);
      endcase
    end
    // R12 mid-run reset after loading every register
    wr(24'h700000, 8'h03);
    wr(24'h600000, 8'hFF);
    wr(24'h600002, 8'h02);
    rd(24'h600000, 5, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    xl(24'h000100, 12, 24'h000100);
    rd(24'h600000, 12, 8'h00);
    wr(24'h600002, 8'h01);
    rd(24'h600000, 12, 8'h00);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule